// File: doc/BRIEF.md
# Radar Packet Streaming Writer

This block turns radar processing results into byte-wide packets for a synchronous transmit FIFO. It runs entirely in the FIFO clock domain. A range sample always opens a packet. Doppler and detection results join the packet only when their stream is switched on and a fresh result is waiting. This means the writer never stalls at start-up waiting for a source that has not yet produced anything.

A three-bit stream-control word arrives from another clock domain and passes through a two-flop synchronizer. Doppler and detection results are latched into holding registers. Each of these sources keeps a sticky pending flag, which is cleared once its section has been written. The FIFO's active-low ready flag throttles every write cycle.

Top module: `radar_pkt_writer`

## Requirements
- R1: In reset and after reset, `wr_en` is 0 and the synchronized stream-control word is 3'b001. Only range packets are produced until a new word has been synchronized, even when doppler or detection results are pending.
- R2: The stream-control word has three bits: bit 0 is the range enable, bit 1 the doppler enable and bit 2 the detection enable. It passes through two flop stages. A `range_valid` sampled at the second clock edge after the word changes still sees the old word. The new word applies from the third edge onward.
- R3: A packet starts only when `range_valid` is sampled high in idle with the range enable set. `dop_valid` or `cfar_valid` alone never produces a write.
- R4: A packet is written one byte per write cycle, in this order:
  - the header 0xAA;
  - the 32-bit range sample that was captured when the packet started, most significant byte first;
  - the optional doppler section;
  - the optional detection section;
  - the footer 0x55.
  After the footer comes one cycle with no write, and then idle.
- R5: The doppler section is written only if the doppler enable is set and the doppler pending flag is set when the last range byte is written. Each `dop_valid` sets the flag. Writing the last doppler byte clears it, unless `dop_valid` arrives in that same cycle, in which case the flag stays set.
- R6: The detection section is a single byte {7'b0, hit}. It is written only if the detection enable and the detection pending flag are both set. Otherwise the detection step lasts one cycle with no write. The detection flag follows the same set and clear rules as the doppler flag.
- R7: While `txe_n` is 1, no write occurs and a writing step does not advance.
- R8: A `range_valid` that arrives while a packet is in progress is dropped. It neither starts a second packet nor changes the range bytes being sent.
- R9: Every `dop_valid` loads `dop_re` and `dop_im` into the holding registers. Each doppler byte is taken from those registers at the moment it is written, in the order re[15:8], re[7:0], im[15:8], im[7:0].
- R10: `wr_be` equals `wr_en`, and `wr_data` is 0 whenever `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_valid | input | 1 | Range sample strobe, the only packet trigger |
| range_data | input | 32 | Range sample |
| dop_valid | input | 1 | Doppler sample strobe |
| dop_re | input | 16 | Doppler real part |
| dop_im | input | 16 | Doppler imaginary part |
| cfar_valid | input | 1 | Detection strobe |
| cfar_hit | input | 1 | Detection result |
| stream_ctl | input | 3 | Stream enables from another clock domain |
| txe_n | input | 1 | FIFO ready, active low |
| wr_data | output | 8 | Byte written to the FIFO |
| wr_be | output | 1 | Byte lane enable |
| wr_en | output | 1 | Write strobe |

## Verification
A wrong sequencer state shows up at the ports in the same cycle. The byte on `wr_data` or the level of `wr_en` departs from the order the packet should have, so a cycle-by-cycle comparison finds it on the first affected write. A pending flag that is wrongly set or cleared is not visible until the next section decision. The bench therefore pairs each flag event with a range trigger, so the mistake appears as an extra or missing doppler or detection section within that packet. A synchronizer with the wrong depth shifts by one cycle the first packet that obeys a new control word.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_RNG, ST_DOP, ST_DET, ST_FTR, ST_ACK
  } wstate_t;

  localparam logic [7:0] HDR_MARK  = 8'hAA;
  localparam logic [7:0] FTR_MARK  = 8'h55;
  localparam logic [2:0] CTL_RESET = 3'b001;
  localparam int EN_RANGE = 0;
  localparam int EN_DOP   = 1;
  localparam int EN_CFAR  = 2;
endpackage

// File: rtl/rpw_sync.sv
module rpw_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rpw_pending.sv
module rpw_pending #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic          pend_o,
  output logic [DW-1:0] hold_o
);
  logic pend_nx;

  // a new strobe wins over a take in the same cycle
  always_comb pend_nx = (pend_o & ~take_i) | set_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     hold_o <= '0;
    else if (set_i) hold_o <= data_i;

  // R5 / R6: flag is sticky until taken
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !take_i) |=> pend_o);
  // R5 / R6: a strobe always leaves the flag set
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  // R9: holding register keeps its value without a strobe
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> $stable(hold_o));
endmodule

// File: rtl/rpw_seq.sv
module rpw_seq
  import rpw_pkg::*;
#(
  parameter int RANGE_W = 32,
  parameter int DOP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 range_valid,
  input  logic [RANGE_W-1:0]   range_data,
  input  logic [2:0]           ctl,
  input  logic                 dop_pend,
  input  logic [2*DOP_W-1:0]   dop_hold,
  input  logic                 cfar_pend,
  input  logic                 cfar_hold,
  input  logic                 txe_n,
  output logic                 dop_take,
  output logic                 cfar_take,
  output logic                 wr_en,
  output logic [7:0]           wr_data
);
  localparam int RNG_BYTES = RANGE_W / 8;
  localparam int DOP_BITS  = 2 * DOP_W;
  localparam int DOP_BYTES = DOP_BITS / 8;
  localparam int MAXB      = (RNG_BYTES > DOP_BYTES) ? RNG_BYTES : DOP_BYTES;
  localparam int IDX_W     = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam logic [IDX_W-1:0] RNG_LAST = IDX_W'(RNG_BYTES - 1);
  localparam logic [IDX_W-1:0] DOP_LAST = IDX_W'(DOP_BYTES - 1);

  wstate_t            state, st_nx;
  logic [IDX_W-1:0]   idx, idx_nx;
  logic [RANGE_W-1:0] rng_hold;
  logic               ld_rng;
  logic               ready;
  logic [RANGE_W-1:0] rng_sh;
  logic [DOP_BITS-1:0] dop_sh;
  logic [7:0]         byte_sel;

  assign ready  = ~txe_n;
  assign rng_sh = rng_hold << {idx, 3'b000};
  assign dop_sh = dop_hold << {idx, 3'b000};

  always_comb begin
    st_nx     = state;
    idx_nx    = idx;
    ld_rng    = 1'b0;
    wr_en     = 1'b0;
    byte_sel  = 8'h00;
    dop_take  = 1'b0;
    cfar_take = 1'b0;
    unique case (state)
      ST_IDLE: if (range_valid && ctl[EN_RANGE]) begin
        st_nx  = ST_HDR;
        ld_rng = 1'b1;
      end
      ST_HDR: if (ready) begin
        wr_en    = 1'b1;
        byte_sel = HDR_MARK;
        idx_nx   = '0;
        st_nx    = ST_RNG;
      end
      ST_RNG: if (ready) begin
        wr_en    = 1'b1;
        byte_sel = rng_sh[RANGE_W-1 -: 8];
        if (idx == RNG_LAST) begin
          idx_nx = '0;
          st_nx  = (ctl[EN_DOP] && dop_pend) ? ST_DOP : ST_DET;
        end else begin
          idx_nx = idx + IDX_W'(1);
        end
      end
      ST_DOP: if (ready) begin
        wr_en    = 1'b1;
        byte_sel = dop_sh[DOP_BITS-1 -: 8];
        if (idx == DOP_LAST) begin
          idx_nx   = '0;
          dop_take = 1'b1;
          st_nx    = ST_DET;
        end else begin
          idx_nx = idx + IDX_W'(1);
        end
      end
      ST_DET: begin
        if (ctl[EN_CFAR] && cfar_pend) begin
          if (ready) begin
            wr_en     = 1'b1;
            byte_sel  = {7'b0, cfar_hold};
            cfar_take = 1'b1;
            st_nx     = ST_FTR;
          end
        end else begin
          st_nx = ST_FTR;
        end
      end
      ST_FTR: if (ready) begin
        wr_en    = 1'b1;
        byte_sel = FTR_MARK;
        st_nx    = ST_ACK;
      end
      ST_ACK: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign wr_data = wr_en ? byte_sel : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= st_nx;
      idx   <= idx_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rng_hold <= '0;
    else if (ld_rng) rng_hold <= range_data;

  // R3: idle is left only on an enabled range strobe
  a_r3_idle_needs_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(range_valid && ctl[EN_RANGE])) |=> state == ST_IDLE);
  // R4: the gap after the footer lasts exactly one cycle
  a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ACK |=> state == ST_IDLE);
  // R7: a stalled writing step holds its position
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_n && state inside {ST_HDR, ST_RNG, ST_DOP, ST_FTR}) |=> ($stable(state) && $stable(idx)));
  // R7: no write while the FIFO is not ready
  a_r7_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    txe_n |-> !wr_en);
  // R5: doppler section entered only with the flag and the enable present
  a_r5_dop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOP && $past(state) == ST_RNG) |-> $past(dop_pend && ctl[EN_DOP]));
  // R8: the captured range sample is frozen during a packet
  a_r8_range_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_IDLE |=> $stable(rng_hold));
endmodule

// File: rtl/radar_pkt_writer.sv
module radar_pkt_writer
  import rpw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        range_valid,
  input  logic [31:0] range_data,
  input  logic        dop_valid,
  input  logic [15:0] dop_re,
  input  logic [15:0] dop_im,
  input  logic        cfar_valid,
  input  logic        cfar_hit,
  input  logic [2:0]  stream_ctl,
  input  logic        txe_n,
  output logic [7:0]  wr_data,
  output logic        wr_be,
  output logic        wr_en
);
  localparam int RANGE_W = 32;
  localparam int DOP_W   = 16;
  localparam int SYNC_N  = 2;

  logic [2:0]         ctl_s;
  logic               dop_pend, dop_take;
  logic [2*DOP_W-1:0] dop_hold;
  logic               cfar_pend, cfar_take;
  logic [0:0]         cfar_hold;

  rpw_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(CTL_RESET)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(stream_ctl), .q(ctl_s)
  );

  rpw_pending #(.DW(2*DOP_W)) u_dop (
    .clk(clk), .rst_n(rst_n), .set_i(dop_valid), .data_i({dop_re, dop_im}),
    .take_i(dop_take), .pend_o(dop_pend), .hold_o(dop_hold)
  );

  rpw_pending #(.DW(1)) u_cfar (
    .clk(clk), .rst_n(rst_n), .set_i(cfar_valid), .data_i(cfar_hit),
    .take_i(cfar_take), .pend_o(cfar_pend), .hold_o(cfar_hold)
  );

  rpw_seq #(.RANGE_W(RANGE_W), .DOP_W(DOP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .range_valid(range_valid), .range_data(range_data),
    .ctl(ctl_s), .dop_pend(dop_pend), .dop_hold(dop_hold),
    .cfar_pend(cfar_pend), .cfar_hold(cfar_hold[0]), .txe_n(txe_n),
    .dop_take(dop_take), .cfar_take(cfar_take), .wr_en(wr_en), .wr_data(wr_data)
  );

  assign wr_be = wr_en;

  // R1: nothing is written while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> !wr_en);
endmodule

// File: tb/sim_radar_pkt_writer.sv
`timescale 1ns/100ps
module sim_radar_pkt_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rv = 1'b0;
  logic [31:0] rdata = '0;
  logic        dv = 1'b0;
  logic [15:0] dre = '0, dim = '0;
  logic        cv = 1'b0, chit = 1'b0;
  logic [2:0]  ctl = 3'b001;
  logic        txe_n = 1'b0;
  logic [7:0]  wr_data;
  logic        wr_be, wr_en;

  always #2.5 clk = ~clk;

  radar_pkt_writer u0 (
    .clk(clk), .rst_n(rst_n), .range_valid(rv), .range_data(rdata),
    .dop_valid(dv), .dop_re(dre), .dop_im(dim), .cfar_valid(cv), .cfar_hit(chit),
    .stream_ctl(ctl), .txe_n(txe_n), .wr_data(wr_data), .wr_be(wr_be), .wr_en(wr_en)
  );

  int checks = 0, errors = 0, nwr = 0;
  bit done = 1'b0;

  // ---------------- reference model ----------------
  int ph, k;            // 0 idle 1 hdr 2 rng 3 dop 4 det 5 ftr 6 gap
  logic [2:0]  s1, s2;
  bit          dp, cp, mdet;
  logic [31:0] mdh, mr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; k = 0; s1 = 3'b001; s2 = 3'b001;
      dp = 0; cp = 0; mdet = 0; mdh = '0; mr = '0;
    end else begin
      automatic bit rdy = !txe_n;
      automatic bit dtk = 0, ctk = 0;
      case (ph)
        0: if (rv && s2[0]) begin mr = rdata; ph = 1; end
        1: if (rdy) begin ph = 2; k = 0; end
        2: if (rdy) begin
             if (k == 3) begin k = 0; ph = (s2[1] && dp) ? 3 : 4; end
             else k++;
           end
        3: if (rdy) begin
             if (k == 3) begin k = 0; dtk = 1; ph = 4; end
             else k++;
           end
        4: if (s2[2] && cp) begin
             if (rdy) begin ctk = 1; ph = 5; end
           end else ph = 5;
        5: if (rdy) ph = 6;
        default: ph = 0;
      endcase
      dp = (dp && !dtk) || dv;
      cp = (cp && !ctk) || cv;
      if (dv) mdh = {dre, dim};
      if (cv) mdet = chit;
      s2 = s1; s1 = ctl;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit ew; logic [7:0] ed; string tag;
    ew = 0; ed = 8'h00;
    if (!txe_n) begin
      case (ph)
        1: begin ew = 1; ed = 8'hAA; end
        2: begin ew = 1; ed = 8'(mr >> (8*(3-k))); end
        3: begin ew = 1; ed = 8'(mdh >> (8*(3-k))); end
        4: if (s2[2] && cp) begin ew = 1; ed = {7'b0, mdet}; end
        5: begin ew = 1; ed = 8'h55; end
        default: ;
      endcase
    end
    if (!rst_n) tag = "R1 reset";
    else if (txe_n && ph inside {1,2,3,5}) tag = "R7 stall";
    else case (ph)
      0: tag = "R3 idle";
      3: tag = "R9/R5 doppler";
      4: tag = "R6 detect";
      default: tag = "R4 sequence";
    endcase
    chk(wr_en === ew && wr_data === ed, tag, {wr_en, wr_data}, {ew, ed});
    chk(wr_be === wr_en && (wr_en || wr_data === 8'h00), "R10 lane/idle data",
        {wr_be, wr_data}, {wr_en, 8'h00});
    if (wr_en) nwr++;
  endtask

  // compare before the edge, then release strobes after it
  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      #1 compare();
      @(posedge clk); #0.5;
      rv = 0; dv = 0; cv = 0;
    end
  endtask

  task automatic expect_writes(input int from, input int exp, input string tag);
    chk(nwr - from == exp, tag, nwr - from, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    // R1: outputs quiet while reset is held
    repeat (3) begin @(negedge clk); chk(wr_en === 0 && wr_be === 0, "R1 in reset", wr_en, 0); end
    @(posedge clk); #0.5 rst_n = 1;
    cyc(2);

    // R3: doppler and detection strobes alone do nothing
    base = nwr;
    dre = 16'h1234; dim = 16'h5678; dv = 1; cyc();
    chit = 1; cv = 1; cyc(6);
    expect_writes(base, 0, "R3 no packet without range");

    // R1: default word is range only, pending data is not sent
    base = nwr;
    rdata = 32'hDEADBEEF; rv = 1; cyc(12);
    expect_writes(base, 6, "R1 range-only packet after reset");

    // R5/R6: all streams on, both sections sent (flags still pending)
    ctl = 3'b111; cyc(3);
    base = nwr;
    rdata = 32'hCAFE0001; rv = 1; cyc(16);
    expect_writes(base, 11, "R5 R6 full packet");

    // R5/R6: flags consumed, next packet is short
    base = nwr;
    rdata = 32'h0BADF00D; rv = 1; cyc(14);
    expect_writes(base, 6, "R5 R6 flags cleared after use");

    // R9/R5: doppler strobes every cycle during a packet, same-cycle set and take
    base = nwr;
    dre = 16'hA1A2; dim = 16'hB1B2; dv = 1; cyc();
    rdata = 32'h11223344; rv = 1;
    for (int i = 0; i < 16; i++) begin dv = 1; dre = 16'(i * 16'h0101); dim = ~dre; cyc(); end
    cyc(4);
    base = nwr;
    rdata = 32'h55667788; rv = 1; cyc(16);
    expect_writes(base, 10, "R5 flag kept when set during take");

    // R7: stalls inside a packet
    base = nwr;
    cv = 1; chit = 0; cyc();
    rdata = 32'h99AABBCC; rv = 1; cyc();
    for (int i = 0; i < 24; i++) begin txe_n = (i % 3 != 0); cyc(); end
    txe_n = 0; cyc(10);
    expect_writes(base, 7, "R7 stalled packet complete");

    // R8: range strobes inside a packet are dropped
    base = nwr;
    rdata = 32'h01020304; rv = 1; cyc();
    for (int i = 0; i < 7; i++) begin rdata = 32'hFFFF0000 + i; rv = 1; cyc(); end
    cyc(6);
    expect_writes(base, 6, "R8 extra range ignored");

    // R2: new word is not seen until the third edge
    ctl = 3'b000; cyc();
    base = nwr;
    rdata = 32'h77777777; rv = 1; cyc(10);
    expect_writes(base, 6, "R2 old word still in force");
    base = nwr;
    rdata = 32'h88888888; rv = 1; cyc(10);
    expect_writes(base, 0, "R2 range disabled after sync");

    // mixed traffic against the model
    ctl = 3'b111; cyc(3);
    for (int i = 0; i < 4000; i++) begin
      rv = ($urandom_range(0, 9) == 0); rdata = $urandom;
      dv = ($urandom_range(0, 6) == 0); dre = 16'($urandom); dim = 16'($urandom);
      cv = ($urandom_range(0, 9) == 0); chit = 1'($urandom);
      txe_n = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 49) == 0) ctl = 3'($urandom);
      cyc();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule